// File: doc/BRIEF.md
# Oversampling serial receiver with parity check

This block turns an asynchronous serial line into bytes. A sample-rate enable (`tick`) pulses either 16 or 8 times per bit period, depending on `fast_mode`. While idle, the receiver watches the line on every tick. A low level starts a frame, and the first such tick sets the bit timer to its first position. From then on the bit timer counts ticks. For each bit, three samples around the middle of the bit are merged by a 2-of-3 vote, which rejects short noise spikes and false start bits.

A frame is a start bit, then eight data bits sent least significant bit first, then an optional parity bit, then one stop bit. Parity mode and oversampling mode are captured when the start is detected. When the stop bit is decided, the data byte, its parity-mismatch flag and its stop-bit status go together into a two-entry queue. The head entry is always shown at the outputs, and a read strobe removes it. Dropping `rx_en` clears the receiver at once: any frame in progress and every queued entry are discarded.

Top module: `uart_rx_os`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle with an empty queue, and after that edge `avail`, `dout`, `par_err`, `frm_err` and `overrun` are all 0.
- R2: With `fast_mode`=0, one bit lasts 16 ticks. The start-detect tick counts as tick 1 of the start bit. The bit value is decided at tick 10 of each bit, from the samples taken at ticks 8, 9 and 10. Data bits are assembled LSB first. The entry appears at the outputs one clock after tick 10 of the stop bit.
- R3: With `fast_mode`=1, one bit lasts 8 ticks. The samples are taken at ticks 4, 5 and 6, and the decision is made at tick 6.
- R4: Each bit takes the majority value of its three samples, so a single wrong sample does not change the received bit.
- R5: If the start bit's vote is 1, nothing is stored and the receiver goes back to looking for a low level.
- R6: With `par_en`=1, a parity bit follows the data. `par_odd`=1 selects odd parity (data plus parity holds an odd number of ones) and 0 selects even parity. `par_err` is 1 for an entry whose parity mismatched. With `par_en`=0 there is no parity bit and `par_err` is 0.
- R7: A stop bit whose vote is 0 still stores the byte, with `frm_err`=1 for that entry.
- R8: The queue holds 2 entries in arrival order. `avail` is 1 while an entry is held, and `dout`, `par_err` and `frm_err` show the head entry. A clock edge with `rd_stb`=1 removes the head. When the queue is empty, all three show 0.
- R9: A frame that completes while the queue is full, with no read in that cycle, is dropped and sets `overrun`. A clock edge with `rd_stb`=1 clears `overrun`.
- R10: A clock edge with `rx_en`=0 abandons any frame, empties the queue and clears `overrun`. While `rx_en` is 0, a low line starts no frame.
- R11: The bit timer moves only on clock edges where `tick` is 1, so reception is correct whatever the spacing of the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Serial input, already synchronous to `clk`, idle high |
| tick | input | 1 | Sample-rate enable, one pulse per sample slot |
| fast_mode | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| rx_en | input | 1 | Receiver enable; 0 clears everything |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_stb | input | 1 | Remove the head entry and clear `overrun` |
| dout | output | 8 | Head entry data byte |
| avail | output | 1 | Queue holds at least one entry |
| par_err | output | 1 | Head entry had a parity mismatch |
| frm_err | output | 1 | Head entry had a low stop bit |
| overrun | output | 1 | A frame was dropped because the queue was full |

## Verification
The hardest states to reach are the ones that depend on tick alignment inside a bit: a single wrong sample at the centre slot, and a start pulse that ends before the first middle sample. The stimulus drives the line one tick slot at a time, changing it only between tick edges, so the bench knows exactly which slot each sample falls in. Overrun requires two frames waiting and a third one completing with no read. Aborting a frame is tested by dropping the enable part way through a frame while one older entry is still queued.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the oversampling receiver.
// Assumes nothing beyond IEEE 1800-2017.
package uart_rx_pkg;

    // Frame sequencer state
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

    // Two-of-three majority
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_os_timer.sv
`timescale 1ns/1ps
// Module: rx_os_timer
// Counts sample ticks within one bit period and captures the three
// middle samples. It reports the majority value on the tick of the
// third sample. Assumes restart is pulsed on the start-detect tick
// and that `fast` is stable for a whole frame.
module rx_os_timer
    import uart_rx_pkg::*;
#(
    parameter int OS_NORM = 16,
    parameter int OS_FAST = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic restart,
    input  logic active,
    input  logic tick,
    input  logic fast,
    input  logic rx,
    output logic bit_done,
    output logic bit_val
);
    localparam int CW = $clog2(OS_NORM + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] os_max;
    logic [CW-1:0] mid;
    logic [CW-1:0] nxt;
    logic [1:0]    smp;

    // Slot arithmetic for the current oversampling mode
    always_comb begin
        os_max = fast ? CW'(OS_FAST) : CW'(OS_NORM);
        mid    = os_max >> 1;
        nxt    = (cnt >= os_max) ? CW'(1) : cnt + CW'(1);
    end

    assign bit_done = active && tick && (nxt == mid + CW'(2));
    assign bit_val  = vote3(smp[0], smp[1], rx);

    // Slot counter and capture of the first two middle samples
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            smp <= '0;
        end else if (restart) begin
            cnt <= CW'(1);
        end else if (active && tick) begin
            cnt <= nxt;
            if (nxt == mid)          smp[0] <= rx;
            if (nxt == mid + CW'(1)) smp[1] <= rx;
        end
    end

    // R11
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart && !clr) |=> $stable(cnt));

    // R2
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(OS_NORM));

endmodule

// File: rtl/rx_fifo.sv
`timescale 1ns/1ps
// Module: rx_fifo
// Small synchronous queue with a combinational head. A push while full
// is accepted only if a pop happens in the same cycle. Assumes clr
// has priority over every other request.
module rx_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CNTW-1:0] cnt;
    logic            do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNTW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rp];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CNTW'(1);
                2'b01:   cnt <= cnt - CNTW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNTW'(DEPTH));

    // R9
    fifo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !clr) |=> full);

endmodule

// File: rtl/uart_rx_os.sv
`timescale 1ns/1ps
// Module: uart_rx_os
// Serial receiver top. It detects the start level, sequences the start,
// data, parity and stop bits, checks parity, and queues each byte with
// its error flags. Assumes rx_line is already synchronous to clk and
// that mode inputs are stable while a frame is in flight (they are
// captured at start detection).
module uart_rx_os
    import uart_rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OS_NORM    = 16,
    parameter int OS_FAST    = 8,
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              tick,
    input  logic              fast_mode,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] dout,
    output logic              avail,
    output logic              par_err,
    output logic              frm_err,
    output logic              overrun
);
    localparam int IW = $clog2(DATA_W + 3);
    localparam int EW = DATA_W + 2;

    rx_state_e         st;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] shreg;
    logic              pbit, fast_l, pen_l, podd_l;
    logic              start_det, bit_done, bit_val, is_stop, push;
    logic              q_empty, q_full, drop;
    logic [EW-1:0]     entry, q_head;

    assign start_det = rx_en && (st == RX_IDLE) && tick && !rx_line;
    assign is_stop   = ((idx == IW'(DATA_W + 1)) && !pen_l) || (idx == IW'(DATA_W + 2));
    assign push      = (st == RX_BUSY) && bit_done && is_stop;
    assign entry     = {shreg, pen_l & (^shreg ^ pbit ^ podd_l), ~bit_val};
    assign drop      = push && q_full && !rd_stb;

    rx_os_timer #(.OS_NORM(OS_NORM), .OS_FAST(OS_FAST)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!rx_en),
        .restart  (start_det),
        .active   (st == RX_BUSY),
        .tick     (tick),
        .fast     (fast_l),
        .rx       (rx_line),
        .bit_done (bit_done),
        .bit_val  (bit_val)
    );

    rx_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!rx_en),
        .push  (push),
        .din   (entry),
        .pop   (rd_stb),
        .head  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    // Frame sequencer: start check, data shift, parity capture, stop
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            st     <= RX_IDLE;
            idx    <= '0;
            shreg  <= '0;
            pbit   <= 1'b0;
            fast_l <= 1'b0;
            pen_l  <= 1'b0;
            podd_l <= 1'b0;
        end else if (start_det) begin
            st     <= RX_BUSY;
            idx    <= '0;
            fast_l <= fast_mode;
            pen_l  <= par_en;
            podd_l <= par_odd;
        end else if (st == RX_BUSY && bit_done) begin
            if (idx == '0) begin
                if (bit_val) st <= RX_IDLE;
                else         idx <= IW'(1);
            end else if (idx <= IW'(DATA_W)) begin
                shreg <= {bit_val, shreg[DATA_W-1:1]};
                idx   <= idx + IW'(1);
            end else if (is_stop) begin
                st <= RX_IDLE;
            end else begin
                pbit <= bit_val;
                idx  <= idx + IW'(1);
            end
        end
    end

    // Sticky dropped-frame flag
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) overrun <= 1'b0;
        else if (rd_stb)      overrun <= 1'b0;
        else if (drop)        overrun <= 1'b1;
    end

    // Head presentation, zero when the queue is empty
    always_comb begin
        avail   = !q_empty;
        dout    = avail ? q_head[EW-1:2] : '0;
        par_err = avail & q_head[1];
        frm_err = avail & q_head[0];
    end

    // R11
    avail_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail) |-> $past(tick));

    // R9
    ovr_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(avail));

    // R10
    disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!avail && !overrun));

endmodule

// File: tb/uart_rx_os_bench.sv
`timescale 1ns/1ps
module uart_rx_os_bench;
    logic       clk = 1'b0, rst_n = 1'b0, rx_line = 1'b1, tick = 1'b0;
    logic       fast_mode = 1'b0, rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0, rd_stb = 1'b0;
    logic [7:0] dout;
    logic       avail, par_err, frm_err, overrun;

    typedef struct packed { logic [7:0] d; logic pe; logic fe; } ent_t;
    ent_t mq[$];
    logic m_ovr = 1'b0;
    int   total = 0, bad = 0, tick_div = 2;
    bit   cmp_on = 1'b0, finished = 1'b0;

    always #10 clk = ~clk;

    uart_rx_os u_uart_rx_os (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick(tick),
        .fast_mode(fast_mode), .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd),
        .rd_stb(rd_stb), .dout(dout), .avail(avail), .par_err(par_err),
        .frm_err(frm_err), .overrun(overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Tick source with adjustable spacing
    initial begin : tickgen
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            c++;
            tick = ((c % tick_div) == 0);
        end
    end

    // Reference comparison on every clock
    always @(negedge clk) begin
        if (cmp_on) begin
            if (mq.size() != 0) begin
                chk("R8 avail", avail, 1);
                chk("R8 dout", dout, mq[0].d);
                chk("R6 par_err", par_err, mq[0].pe);
                chk("R7 frm_err", frm_err, mq[0].fe);
            end else begin
                chk("R8 avail empty", avail, 0);
                chk("R8 dout empty", dout, 0);
                chk("R6 par_err empty", par_err, 0);
                chk("R7 frm_err empty", frm_err, 0);
            end
            chk("R9 overrun", overrun, m_ovr);
        end
    end

    task automatic wait_tick();
        do @(posedge clk); while (tick !== 1'b1);
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    task automatic send_frame(input logic [7:0] d, input bit pen, input bit podd,
                              input bit bad_par, input bit stop_v,
                              input int noise_bit, input int cut_bit);
        int os;
        int m;
        int nb;
        logic [10:0] bits;
        ent_t e;
        os = fast_mode ? 8 : 16;
        m  = os / 2;
        nb = pen ? 11 : 10;
        bits = '1;
        bits[0] = 1'b0;
        bits[8:1] = d;
        if (pen) bits[9] = (^d) ^ podd ^ bad_par;
        bits[nb-1] = stop_v;
        @(negedge clk);
        par_en = pen;
        par_odd = podd;
        for (int k = 0; k < nb; k++) begin
            if (k == cut_bit) begin
                @(negedge clk);
                rx_line = 1'b1;
                rx_en = 1'b0;
                @(posedge clk);
                mq.delete();
                m_ovr = 1'b0;
                @(negedge clk);
                rx_en = 1'b1;
                return;
            end
            for (int t = 1; t <= os; t++) begin
                @(negedge clk);
                rx_line = (k == noise_bit && t == m + 1) ? ~bits[k] : bits[k];
                wait_tick();
                if (k == nb - 1 && t == m + 2) begin
                    if (mq.size() < 2) begin
                        e.d = d; e.pe = pen & bad_par; e.fe = ~stop_v;
                        mq.push_back(e);
                    end else begin
                        m_ovr = 1'b1;
                    end
                end
            end
        end
        @(negedge clk);
        rx_line = 1'b1;
        idle_ticks(2);
        @(negedge clk);
    endtask

    task automatic glitch(input int len);
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            rx_line = (t < len) ? 1'b0 : 1'b1;
            wait_tick();
        end
        @(negedge clk);
    endtask

    task automatic do_read();
        ent_t tmp;
        @(negedge clk);
        rd_stb = 1'b1;
        @(posedge clk);
        if (mq.size() != 0) tmp = mq.pop_front();
        m_ovr = 1'b0;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic head_is(input string tag, input int d, input int pe, input int fe);
        chk(tag, avail, 1);
        chk(tag, dout, d);
        chk(tag, par_err, pe);
        chk(tag, frm_err, fe);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 avail", avail, 0);
        chk("R1 dout", dout, 0);
        chk("R1 par_err", par_err, 0);
        chk("R1 frm_err", frm_err, 0);
        chk("R1 overrun", overrun, 0);
        rst_n = 1'b1;
        rx_en = 1'b1;
        cmp_on = 1'b1;
        idle_ticks(3);

        // R2 plain 16x frame, LSB first
        send_frame(8'hA5, 0, 0, 0, 1, -1, -1);
        head_is("R2 16x frame", 8'hA5, 0, 0);
        do_read();
        send_frame(8'h01, 0, 0, 0, 1, -1, -1);
        head_is("R2 lsb first", 8'h01, 0, 0);
        do_read();

        // R6 parity: even good, odd good, even bad, odd bad
        send_frame(8'h3C, 1, 0, 0, 1, -1, -1);
        head_is("R6 even ok", 8'h3C, 0, 0);
        do_read();
        send_frame(8'h81, 1, 1, 0, 1, -1, -1);
        head_is("R6 odd ok", 8'h81, 0, 0);
        do_read();
        send_frame(8'h7E, 1, 0, 1, 1, -1, -1);
        head_is("R6 even bad", 8'h7E, 1, 0);
        do_read();
        send_frame(8'h10, 1, 1, 1, 1, -1, -1);
        head_is("R6 odd bad", 8'h10, 1, 0);
        do_read();

        // R7 low stop bit
        send_frame(8'hC3, 0, 0, 0, 0, -1, -1);
        head_is("R7 stop low", 8'hC3, 0, 1);
        do_read();

        // R4 single wrong middle sample in a data bit and in the start bit
        send_frame(8'h55, 0, 0, 0, 1, 4, -1);
        head_is("R4 noisy data bit", 8'h55, 0, 0);
        do_read();
        send_frame(8'hF0, 0, 0, 0, 1, 0, -1);
        head_is("R4 noisy start bit", 8'hF0, 0, 0);
        do_read();

        // R5 short start pulse rejected, then a real frame
        glitch(3);
        chk("R5 glitch stores nothing", avail, 0);
        send_frame(8'h9B, 0, 0, 0, 1, -1, -1);
        head_is("R5 frame after glitch", 8'h9B, 0, 0);
        do_read();

        // R3 double-speed frames
        fast_mode = 1'b1;
        send_frame(8'h5A, 1, 1, 1, 1, -1, -1);
        head_is("R3 fast parity bad", 8'h5A, 1, 0);
        do_read();
        send_frame(8'h26, 0, 0, 0, 1, 6, -1);
        head_is("R3 fast noisy bit", 8'h26, 0, 0);
        do_read();
        glitch(2);
        chk("R3 fast glitch rejected", avail, 0);
        fast_mode = 1'b0;

        // R8 ordering, R9 overrun
        send_frame(8'h11, 0, 0, 0, 1, -1, -1);
        send_frame(8'h22, 1, 0, 1, 1, -1, -1);
        head_is("R8 first of two", 8'h11, 0, 0);
        send_frame(8'h33, 0, 0, 0, 1, -1, -1);
        chk("R9 overrun set", overrun, 1);
        head_is("R9 head kept", 8'h11, 0, 0);
        do_read();
        chk("R9 overrun cleared by read", overrun, 0);
        head_is("R8 second entry", 8'h22, 1, 0);
        do_read();
        chk("R8 drained", avail, 0);

        // R10 disable mid-frame with one entry queued
        send_frame(8'h44, 0, 0, 0, 1, -1, -1);
        send_frame(8'h66, 0, 0, 0, 1, -1, 4);
        chk("R10 queue flushed", avail, 0);
        @(negedge clk);
        rx_en = 1'b0;
        rx_line = 1'b0;
        repeat (40) @(negedge clk);
        rx_line = 1'b1;
        @(negedge clk);
        rx_en = 1'b1;
        idle_ticks(20);
        @(negedge clk);
        chk("R10 no start while off", avail, 0);
        send_frame(8'h6D, 0, 0, 0, 1, -1, -1);
        head_is("R10 frame after re-enable", 8'h6D, 0, 0);
        do_read();

        // R11 other tick spacings
        tick_div = 3;
        idle_ticks(2);
        send_frame(8'hB7, 1, 1, 0, 1, -1, -1);
        head_is("R11 tick every 3", 8'hB7, 0, 0);
        do_read();
        tick_div = 1;
        idle_ticks(2);
        send_frame(8'h4E, 0, 0, 0, 1, -1, -1);
        head_is("R11 tick every clock", 8'h4E, 0, 0);
        do_read();

        idle_ticks(4);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule